// File: doc/BRIEF.md
# Undo-Log Transactional Store Unit

This unit sits between one hardware thread and a plain word-addressed data RAM and gives that thread eager-versioned transactions. Inside a transaction every store goes straight to its home address. Before that happens, the first store to any given word copies the word's previous contents into a private undo log, which lives in a reserved window of the same RAM. Commit is meant to be the common case, so it costs one cycle: the log pointer returns to the bottom of the window and the per-word "already logged" bits are wiped. Abort is the rare and slow path. It reads the log from the newest entry back to the oldest, writes each saved word back to its home address, and then raises a one-cycle done pulse.

The thread drives a command port (begin, end, abort) and a request port (load, store). It may issue either only while `busy` is low. When both are valid in the same cycle, the command is taken and the request is dropped. A log entry takes two consecutive RAM words starting at `LOG_BASE + 2*k`. The first word holds the target address and the second holds the old data. The log has room for `LOG_ENTRIES` entries. A first-time store that finds the log full is refused and flagged. The RAM must return read data on the cycle after a read request.

The controller has these states. `S_IDLE` accepts commands and requests. Store path: `S_RD_OLD` reads the old word, `S_LOG_A` writes the address word, `S_LOG_D` writes the old-data word and advances the pointer, and `S_WR` writes in place. Load path: `S_LD` reads and `S_LD_RSP` returns the data. Abort path: `S_AB_RA` reads an entry's address word, `S_AB_RD` reads its data word, `S_AB_WR` restores and steps the pointer down, and `S_AB_DONE` pulses done and clears the transaction. The transitions are:
- IDLE→RD_OLD on a first logged store with room in the log.
- IDLE→WR on any other store.
- IDLE→LD on a load.
- IDLE→AB_RA on an abort with a non-empty log.
- IDLE→AB_DONE on an abort with an empty log.
- RD_OLD→LOG_A→LOG_D→WR→IDLE.
- LD→LD_RSP→IDLE.
- AB_RA→AB_RD→AB_WR.
- AB_WR→AB_RA while entries remain, otherwise AB_WR→AB_DONE.
- AB_DONE→IDLE.

Top module: `txlog_unit`

## Requirements
- R1: `cmd_op` = 2'b01 (begin), issued while no transaction is open, sets `in_tx`. Commands and requests are accepted only in a cycle where `busy` is low.
- R2: Inside a transaction, the first store to a word writes log entry k (k = entries already held, starting at 0). It puts the address at `LOG_BASE+2k` and the previous data at `LOG_BASE+2k+1`, and only after that writes the new value to the word itself.
- R3: A repeated store to an already-logged word in the same transaction updates memory in place and adds no log entry.
- R4: A store outside a transaction writes memory in place and writes nothing into the log window.
- R5: A load makes `resp_valid` high for exactly one cycle, with `resp_rdata` equal to the stored word.
- R6: `cmd_op` = 2'b10 (end), issued inside a transaction, clears `in_tx` and empties the log in one cycle. A later aborted transaction then restores nothing that was written before the commit.
- R7: `cmd_op` = 2'b11 (abort), issued inside a transaction, restores every logged word from the newest entry to the oldest. It then makes `abort_done` high for exactly one cycle and clears `in_tx`.
- R8: An abort with an empty log completes and still gives exactly one `abort_done` pulse.
- R9: A first-time store that finds `LOG_ENTRIES` entries in the log raises `ovf_err` for the one cycle after it is accepted. It writes no memory and leaves the transaction open. Stores to words that are already logged still proceed.
- R10: End or abort outside a transaction, and begin inside one, have no effect. A stray begin does not reset the log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 01 begin, 10 end, 11 abort |
| req_valid | input | 1 | Load/store request present |
| req_we | input | 1 | 1 store, 0 load |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| resp_valid | output | 1 | Load data valid |
| resp_rdata | output | DW | Load data |
| busy | output | 1 | Controller not idle |
| in_tx | output | 1 | Transaction open |
| ovf_err | output | 1 | Store refused, log full |
| abort_done | output | 1 | Rollback finished |
| mem_req | output | 1 | RAM access |
| mem_we | output | 1 | RAM write |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, one cycle after request |

## Verification
The bench targets the log-full boundary. It checks that the refused store leaves its word untouched, and that a later store to a word already in the log still proceeds; a design with an off-by-one limit would either corrupt the log area or refuse a legal store. It records the write order during rollback to catch a design that walks the log forwards. It also checks that repeated stores to a word create no second entry, that commit truly discards the log so a later abort cannot resurrect committed data, and that stray commands neither open, close nor reset a transaction.

// File: rtl/txlog_pkg.sv
package txlog_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_BEGIN = 2'b01,
        OP_END   = 2'b10,
        OP_ABORT = 2'b11
    } tx_op_t;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_OLD, S_LOG_A, S_LOG_D, S_WR,
        S_LD, S_LD_RSP, S_AB_RA, S_AB_RD, S_AB_WR, S_AB_DONE
    } tx_state_t;
endpackage

// File: rtl/txlog_wbits.sv
module txlog_wbits #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set,
    input  logic [AW-1:0] set_idx,
    input  logic          clr,
    input  logic [AW-1:0] q_idx,
    output logic          hit
);
    localparam int WORDS = 1 << AW;

    logic [WORDS-1:0] bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bits <= '0;
        else if (clr)
            bits <= '0;
        else if (set)
            bits[set_idx] <= 1'b1;
    end

    assign hit = bits[q_idx];

    AST_WBIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !clr) |=> bits[$past(set_idx)]); // R3
endmodule

// File: rtl/txlog_ptr.sv
module txlog_ptr #(
    parameter int ENTRIES = 4,
    parameter int PW      = $clog2(ENTRIES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          clr,
    output logic [PW-1:0] ptr,
    output logic          full,
    output logic          empty
);
    localparam logic [PW-1:0] LIMIT = PW'(ENTRIES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (clr)
            ptr <= '0;
        else if (inc)
            ptr <= ptr + 1'b1;
        else if (dec)
            ptr <= ptr - 1'b1;
    end

    assign full  = (ptr == LIMIT);
    assign empty = (ptr == '0);

    AST_NO_INC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !full); // R9
    AST_NO_DEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !empty); // R7
endmodule

// File: rtl/txlog_unit.sv
module txlog_unit #(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int LOG_BASE    = 192,
    parameter int LOG_ENTRIES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          resp_valid,
    output logic [DW-1:0] resp_rdata,
    output logic          busy,
    output logic          in_tx,
    output logic          ovf_err,
    output logic          abort_done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    import txlog_pkg::*;

    localparam int PW = $clog2(LOG_ENTRIES + 1);
    localparam logic [AW-1:0] BASE_A = AW'(LOG_BASE);

    tx_state_t     state, nstate;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q, old_q;
    logic [PW-1:0] log_ptr;
    logic          ptr_full, ptr_empty, wb_hit;
    logic          ptr_inc, ptr_dec, ptr_clr, wb_set, wb_clr;
    logic          tx_set, tx_clr, ovf_set;
    logic [AW-1:0] ent_new, ent_top;
    tx_op_t        op;

    assign op      = tx_op_t'(cmd_op);
    assign ent_new = BASE_A + (AW'(log_ptr) << 1);
    assign ent_top = BASE_A + (AW'(log_ptr - 1'b1) << 1);

    txlog_ptr #(.ENTRIES(LOG_ENTRIES), .PW(PW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .inc(ptr_inc), .dec(ptr_dec), .clr(ptr_clr),
        .ptr(log_ptr), .full(ptr_full), .empty(ptr_empty)
    );

    txlog_wbits #(.AW(AW)) u_wbits (
        .clk(clk), .rst_n(rst_n), .set(wb_set), .set_idx(addr_q), .clr(wb_clr),
        .q_idx(req_addr), .hit(wb_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // next state and control
    always_comb begin
        nstate  = state;
        ptr_inc = 1'b0; ptr_dec = 1'b0; ptr_clr = 1'b0;
        wb_set  = 1'b0; wb_clr  = 1'b0;
        tx_set  = 1'b0; tx_clr  = 1'b0; ovf_set = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (cmd_valid) begin
                    if (op == OP_BEGIN && !in_tx) begin
                        tx_set = 1'b1;
                    end else if (op == OP_END && in_tx) begin
                        tx_clr = 1'b1; ptr_clr = 1'b1; wb_clr = 1'b1;
                    end else if (op == OP_ABORT && in_tx) begin
                        nstate = ptr_empty ? S_AB_DONE : S_AB_RA;
                    end
                end else if (req_valid) begin
                    if (!req_we)
                        nstate = S_LD;
                    else if (in_tx && !wb_hit) begin
                        if (ptr_full) ovf_set = 1'b1;
                        else          nstate  = S_RD_OLD;
                    end else
                        nstate = S_WR;
                end
            end
            S_RD_OLD:  nstate = S_LOG_A;
            S_LOG_A:   nstate = S_LOG_D;
            S_LOG_D: begin
                ptr_inc = 1'b1; wb_set = 1'b1; nstate = S_WR;
            end
            S_WR:      nstate = S_IDLE;
            S_LD:      nstate = S_LD_RSP;
            S_LD_RSP:  nstate = S_IDLE;
            S_AB_RA:   nstate = S_AB_RD;
            S_AB_RD:   nstate = S_AB_WR;
            S_AB_WR: begin
                ptr_dec = 1'b1;
                nstate  = (log_ptr == PW'(1)) ? S_AB_DONE : S_AB_RA;
            end
            S_AB_DONE: begin
                ptr_clr = 1'b1; wb_clr = 1'b1; tx_clr = 1'b1; nstate = S_IDLE;
            end
            default:   nstate = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req = 1'b0; mem_we = 1'b0; mem_addr = addr_q; mem_wdata = data_q;
        resp_valid = 1'b0; abort_done = 1'b0;
        unique case (state)
            S_RD_OLD:  mem_req = 1'b1;
            S_LOG_A:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ent_new;
                             mem_wdata = DW'(addr_q); end
            S_LOG_D:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ent_new + 1'b1;
                             mem_wdata = old_q; end
            S_WR:      begin mem_req = 1'b1; mem_we = 1'b1; end
            S_LD:      mem_req = 1'b1;
            S_LD_RSP:  resp_valid = 1'b1;
            S_AB_RA:   begin mem_req = 1'b1; mem_addr = ent_top; end
            S_AB_RD:   begin mem_req = 1'b1; mem_addr = ent_top + 1'b1; end
            S_AB_WR:   begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = mem_rdata; end
            S_AB_DONE: abort_done = 1'b1;
            default:   ;
        endcase
    end

    assign busy       = (state != S_IDLE);
    assign resp_rdata = mem_rdata;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0; data_q <= '0; old_q <= '0;
            in_tx  <= 1'b0; ovf_err <= 1'b0;
        end else begin
            ovf_err <= ovf_set;
            if (tx_set)      in_tx <= 1'b1;
            else if (tx_clr) in_tx <= 1'b0;
            if (state == S_IDLE && req_valid && !cmd_valid) begin
                addr_q <= req_addr; data_q <= req_wdata;
            end
            if (state == S_LOG_A) old_q  <= mem_rdata;
            if (state == S_AB_RD) addr_q <= AW'(mem_rdata);
        end
    end

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cmd_valid && op == OP_END && in_tx)
        |=> (!in_tx && log_ptr == '0)); // R6
    AST_ABORT_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        abort_done |-> (log_ptr == '0 && in_tx)); // R7
    AST_ABORT_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_done |=> (!abort_done && !in_tx)); // R8
    AST_OVF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> !mem_we); // R9
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R5
    AST_BEGIN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cmd_valid && op == OP_BEGIN) |=> in_tx); // R1
endmodule

// File: tb/txlog_unit_test.sv
module txlog_unit_test;
    localparam int AW = 8, DW = 16, LB = 192, LE = 4;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          cmd_valid = 1'b0, req_valid = 1'b0, req_we = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          resp_valid, busy, in_tx, ovf_err, abort_done;
    logic          mem_req, mem_we;
    logic [DW-1:0] resp_rdata, mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [AW-1:0] mem_addr;

    logic [DW-1:0] ram [0:(1<<AW)-1];
    logic [AW-1:0] wlog [0:15];
    int            wcnt = 0;
    logic          rec_en = 1'b0;

    int checks = 0, errors = 0;
    int n_abort, n_ovf, n_resp;
    logic [DW-1:0] last_resp;

    always #5 clk = ~clk;

    txlog_unit #(.AW(AW), .DW(DW), .LOG_BASE(LB), .LOG_ENTRIES(LE)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .busy(busy), .in_tx(in_tx), .ovf_err(ovf_err), .abort_done(abort_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // RAM model: synchronous read, data one cycle after the request
    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= ram[mem_addr];
            if (mem_we) begin
                ram[mem_addr] <= mem_wdata;
                if (rec_en && wcnt < 16) begin
                    wlog[wcnt] <= mem_addr;
                    wcnt <= wcnt + 1;
                end
            end
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_idle();
        n_abort = 0; n_ovf = 0; n_resp = 0;
        forever begin
            if (abort_done) n_abort++;
            if (ovf_err)    n_ovf++;
            if (resp_valid) begin n_resp++; last_resp = resp_rdata; end
            if (!busy && !ovf_err) break;
            @(negedge clk);
        end
    endtask

    task automatic cmd(input logic [1:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
        run_idle();
    endtask

    task automatic store(input int a, input int d);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = AW'(a); req_wdata = DW'(d);
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        run_idle();
    endtask

    task automatic load(input int a);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = AW'(a);
        @(negedge clk);
        req_valid = 1'b0;
        run_idle();
    endtask

    task automatic t_reset();
        check(!busy && !in_tx && !ovf_err && !abort_done && !resp_valid,
              "R1 reset idle", {busy, in_tx, ovf_err, abort_done}, 0);
    endtask

    task automatic t_plain();
        logic [DW-1:0] logw = ram[LB];
        store(5, 16'hAAAA);
        check(ram[5] == 16'hAAAA, "R4 plain store in place", ram[5], 16'hAAAA);
        check(ram[LB] == logw, "R4 log window untouched", ram[LB], logw);
        load(5);
        check(n_resp == 1, "R5 one resp pulse", n_resp, 1);
        check(last_resp == 16'hAAAA, "R5 load data", last_resp, 16'hAAAA);
        cmd(2'b10);
        check(!in_tx, "R10 end outside tx ignored", in_tx, 0);
        cmd(2'b11);
        check(n_abort == 0 && !in_tx, "R10 abort outside tx ignored", n_abort, 0);
    endtask

    task automatic t_commit();
        cmd(2'b01);
        check(in_tx, "R1 begin opens tx", in_tx, 1);
        store(10, 16'h1111);
        check(ram[10] == 16'h1111, "R2 in-place write", ram[10], 16'h1111);
        check(ram[LB] == 16'd10, "R2 entry0 address word", ram[LB], 10);
        check(ram[LB+1] == 16'h100A, "R2 entry0 old data", ram[LB+1], 16'h100A);
        store(10, 16'h2222);
        check(ram[10] == 16'h2222, "R3 repeat store in place", ram[10], 16'h2222);
        check(ram[LB+2] == DW'(16'h1000 + LB + 2), "R3 no second entry",
              ram[LB+2], 16'h1000 + LB + 2);
        cmd(2'b10);
        check(!in_tx, "R6 commit closes tx", in_tx, 0);
        cmd(2'b01);
        cmd(2'b11);
        check(ram[10] == 16'h2222, "R6 committed data survives abort", ram[10], 16'h2222);
        check(n_abort == 1 && !in_tx, "R8 empty abort one pulse", n_abort, 1);
    endtask

    task automatic t_abort();
        cmd(2'b01);
        store(20, 16'hA0A0);
        cmd(2'b01);                      // stray begin must not reset log
        check(in_tx, "R10 begin inside tx keeps tx", in_tx, 1);
        store(21, 16'hB0B0);
        store(20, 16'hC0C0);
        wcnt = 0; rec_en = 1'b1;
        cmd(2'b11);
        rec_en = 1'b0;
        check(n_abort == 1, "R7 one abort_done pulse", n_abort, 1);
        check(!in_tx, "R7 tx closed after abort", in_tx, 0);
        check(wcnt == 2, "R3 R7 two restores", wcnt, 2);
        check(wlog[0] == 21 && wlog[1] == 20, "R7 newest restored first",
              {wlog[0], wlog[1]}, {8'd21, 8'd20});
        check(ram[20] == 16'h1014, "R7 word20 restored", ram[20], 16'h1014);
        check(ram[21] == 16'h1015, "R7 R10 word21 restored", ram[21], 16'h1015);
    endtask

    task automatic t_overflow();
        cmd(2'b01);
        for (int i = 0; i < LE; i++) begin
            store(40 + i, 16'h5000 + i);
            check(n_ovf == 0, "R9 store within limit accepted", n_ovf, 0);
        end
        store(40 + LE, 16'hDEAD);
        check(n_ovf == 1, "R9 overflow flagged once", n_ovf, 1);
        check(ram[40+LE] == DW'(16'h1000 + 40 + LE), "R9 refused store no write",
              ram[40+LE], 16'h1000 + 40 + LE);
        check(in_tx, "R9 tx stays open", in_tx, 1);
        store(41, 16'h7777);
        check(n_ovf == 0 && ram[41] == 16'h7777, "R9 logged word still stored",
              ram[41], 16'h7777);
        cmd(2'b11);
        for (int i = 0; i < LE; i++)
            check(ram[40+i] == DW'(16'h1000 + 40 + i), "R7 R9 rollback at limit",
                  ram[40+i], 16'h1000 + 40 + i);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) ram[i] = DW'(16'h1000 + i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_commit();
        t_abort();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule